// File: doc/BRIEF.md
# OLED Controller Power-Up Sequencer

This block brings a grayscale OLED display controller out of reset and into a working state over a four-wire serial link. It owns the chip-select, data/command and display-reset lines, and hands command bytes one at a time to a separate SPI shift register through a valid/ready handshake. Fixed millisecond waits are timed with a one-millisecond tick derived from the clock frequency parameter. The sequence is an escape-coded command table that mixes line controls, waits and bytes. It includes a two-stage turn-on: the panel is first lit with every pixel on, then switched to normal mode after a 200 ms hold.

When bring-up completes, a sticky done flag rises. From then on the block accepts contrast requests. Each one is sent as a contrast command followed by the requested level halved. A request that arrives early, or while another contrast transfer is in flight, is kept pending and served as soon as the block is free.

Top module: `oled_bringup_seq`

## Requirements
- R1: While reset is held, and on its release, the outputs are: csN = 1 (chip not selected), dcSel = 1, oledRstN = 1, cmdValid = 0 and done = 0.
- R2: About 10 ms after reset release (10·T to 10·T+10 clock cycles, where T = CLK_HZ/1000), dcSel goes to 0, which means command mode. At that moment csN is still 1.
- R3: After dcSel goes low, oledRstN is driven low for 18 ms (18·T to 18·T+6 cycles) and then returns high. csN stays 1 for as long as oledRstN is low.
- R4: Every byte is offered (cmdValid = 1) only while csN = 0 and dcSel = 0.
- R5: Bring-up sends exactly 42 bytes, in this order: AE, B3 91, A8 3F, A2 4C, A1 00, AD 02, A0 56, 86, B8 01 11 22 32 43 54 65 76, 81 70, B2 51, B1 55, BC 10, B4 02, B0 28, BE 1C, BF 0F, A5, AF, A4 (all hexadecimal).
- R6: Between the acceptance of AF and the acceptance of A4 there are two 100 ms waits, which gives a gap of 200·T to 200·T+40 cycles.
- R7: A byte is accepted on a cycle where cmdValid and cmdReady are both 1. Until that cycle, cmdValid and cmdByte are held. A new byte is offered only once shifterIdle has shown that the previous byte has been shifted out.
- R8: done rises exactly one clock cycle after csN is released at the end of bring-up. It then stays 1 until reset.
- R9: A contrast request is a one-cycle pulse on contrastReq carrying the level on contrastVal. It sends 81 followed by contrastVal >> 1, and then sets csN back to 1.
- R10: A contrast request made before done is held. Its bytes come after the rise of done, and the bring-up stream is left unchanged.
- R11: A request that arrives while a contrast transfer is in progress is served after it, with its own value. The result is two complete 81/level pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| contrastReq | input | 1 | One-cycle contrast request strobe |
| contrastVal | input | 8 | Requested contrast level |
| cmdReady | input | 1 | Shifter can take a byte this cycle |
| shifterIdle | input | 1 | Shifter has no byte in progress |
| cmdValid | output | 1 | Byte on cmdByte is offered |
| cmdByte | output | 8 | Command byte to the shifter |
| csN | output | 1 | Display chip select, active low |
| dcSel | output | 1 | Data/command select, 0 = command |
| oledRstN | output | 1 | Display reset, active low |
| done | output | 1 | Bring-up complete, sticky |

## Verification
If the table pointer is off by one entry, the bench sees it straight away as the wrong byte at a known position in the accepted stream. A wrong line level shows up as csN or dcSel being at the wrong value on the next accepted byte. If the prescaler or the millisecond counter is wrong, the dcSel fall, the reset pulse width or the AF-to-A4 gap falls outside its cycle window, and this is visible within one delay step. A lost or merged contrast request shows up as a missing or wrong 81/level pair once the sequence finishes.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

  localparam int BYTE_W    = 8;
  localparam int MS_W      = 8;
  localparam int PC_W      = 6;
  localparam int ROM_DEPTH = 59;
  localparam logic [PC_W-1:0] CTR_ENTRY = PC_W'(53);

  typedef enum logic [2:0] {
    OP_SEND, OP_SENDCTR, OP_WAIT, OP_CS, OP_DC, OP_RST, OP_END, OP_RET
  } seqOp_t;

  typedef struct packed {
    seqOp_t            op;
    logic [BYTE_W-1:0] arg;
  } romWord_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DELAY, ST_SEND, ST_DRAIN, ST_IDLE
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadDelay;
    logic [MS_W-1:0]   delayMs;
    logic              csWrite;
    logic              csSelect;
    logic              dcWrite;
    logic              dcLevel;
    logic              rstWrite;
    logic              rstLevel;
    logic              loadByte;
    logic [BYTE_W-1:0] byteVal;
    logic              loadCtr;
    logic              startCtr;
    logic              setDone;
  } dpCtl_t;

  function automatic romWord_t mk(input seqOp_t op, input logic [7:0] arg);
    romWord_t w;
    w.op  = op;
    w.arg = arg;
    return w;
  endfunction

  // Bring-up program (0..52) followed by the contrast routine (53..58)
  function automatic romWord_t romRead(input logic [PC_W-1:0] idx);
    case (idx)
      6'd0:  romRead = mk(OP_WAIT, 8'd10);
      6'd1:  romRead = mk(OP_CS,   8'd0);
      6'd2:  romRead = mk(OP_DC,   8'd0);
      6'd3:  romRead = mk(OP_RST,  8'd0);
      6'd4:  romRead = mk(OP_WAIT, 8'd18);
      6'd5:  romRead = mk(OP_RST,  8'd1);
      6'd6:  romRead = mk(OP_CS,   8'd1);
      6'd7:  romRead = mk(OP_SEND, 8'hAE);
      6'd8:  romRead = mk(OP_SEND, 8'hB3);
      6'd9:  romRead = mk(OP_SEND, 8'h91);
      6'd10: romRead = mk(OP_SEND, 8'hA8);
      6'd11: romRead = mk(OP_SEND, 8'h3F);
      6'd12: romRead = mk(OP_SEND, 8'hA2);
      6'd13: romRead = mk(OP_SEND, 8'h4C);
      6'd14: romRead = mk(OP_SEND, 8'hA1);
      6'd15: romRead = mk(OP_SEND, 8'h00);
      6'd16: romRead = mk(OP_SEND, 8'hAD);
      6'd17: romRead = mk(OP_SEND, 8'h02);
      6'd18: romRead = mk(OP_SEND, 8'hA0);
      6'd19: romRead = mk(OP_SEND, 8'h56);
      6'd20: romRead = mk(OP_SEND, 8'h86);
      6'd21: romRead = mk(OP_SEND, 8'hB8);
      6'd22: romRead = mk(OP_SEND, 8'h01);
      6'd23: romRead = mk(OP_SEND, 8'h11);
      6'd24: romRead = mk(OP_SEND, 8'h22);
      6'd25: romRead = mk(OP_SEND, 8'h32);
      6'd26: romRead = mk(OP_SEND, 8'h43);
      6'd27: romRead = mk(OP_SEND, 8'h54);
      6'd28: romRead = mk(OP_SEND, 8'h65);
      6'd29: romRead = mk(OP_SEND, 8'h76);
      6'd30: romRead = mk(OP_SEND, 8'h81);
      6'd31: romRead = mk(OP_SEND, 8'h70);
      6'd32: romRead = mk(OP_SEND, 8'hB2);
      6'd33: romRead = mk(OP_SEND, 8'h51);
      6'd34: romRead = mk(OP_SEND, 8'hB1);
      6'd35: romRead = mk(OP_SEND, 8'h55);
      6'd36: romRead = mk(OP_SEND, 8'hBC);
      6'd37: romRead = mk(OP_SEND, 8'h10);
      6'd38: romRead = mk(OP_SEND, 8'hB4);
      6'd39: romRead = mk(OP_SEND, 8'h02);
      6'd40: romRead = mk(OP_SEND, 8'hB0);
      6'd41: romRead = mk(OP_SEND, 8'h28);
      6'd42: romRead = mk(OP_SEND, 8'hBE);
      6'd43: romRead = mk(OP_SEND, 8'h1C);
      6'd44: romRead = mk(OP_SEND, 8'hBF);
      6'd45: romRead = mk(OP_SEND, 8'h0F);
      6'd46: romRead = mk(OP_SEND, 8'hA5);
      6'd47: romRead = mk(OP_SEND, 8'hAF);
      6'd48: romRead = mk(OP_WAIT, 8'd100);
      6'd49: romRead = mk(OP_WAIT, 8'd100);
      6'd50: romRead = mk(OP_SEND, 8'hA4);
      6'd51: romRead = mk(OP_CS,   8'd0);
      6'd52: romRead = mk(OP_END,  8'd0);
      6'd53: romRead = mk(OP_CS,   8'd1);
      6'd54: romRead = mk(OP_DC,   8'd0);
      6'd55: romRead = mk(OP_SEND, 8'h81);
      6'd56: romRead = mk(OP_SENDCTR, 8'd0);
      6'd57: romRead = mk(OP_CS,   8'd0);
      default: romRead = mk(OP_RET, 8'd0);
    endcase
  endfunction

endpackage

// File: rtl/oled_seq_ctrl.sv
module oled_seq_ctrl
  import oled_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   delayDone,
  input  logic   ctrPending,
  input  logic   cmdReady,
  input  logic   shifterIdle,
  output dpCtl_t ctl,
  output logic   cmdValid
);

  ctrlState_t      state, nextState;
  logic [PC_W-1:0] pc, nextPc;
  romWord_t        word;

  assign word     = romRead(pc);
  assign cmdValid = (state == ST_SEND);

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextPc    = pc;
    case (state)
      ST_FETCH: begin
        case (word.op)
          OP_SEND: begin
            ctl.loadByte = 1'b1;
            ctl.byteVal  = word.arg;
            nextState    = ST_SEND;
          end
          OP_SENDCTR: begin
            ctl.loadCtr = 1'b1;
            nextState   = ST_SEND;
          end
          OP_WAIT: begin
            ctl.loadDelay = 1'b1;
            ctl.delayMs   = word.arg;
            nextState     = ST_DELAY;
          end
          OP_CS: begin
            ctl.csWrite  = 1'b1;
            ctl.csSelect = word.arg[0];
            nextPc       = pc + PC_W'(1);
          end
          OP_DC: begin
            ctl.dcWrite = 1'b1;
            ctl.dcLevel = word.arg[0];
            nextPc      = pc + PC_W'(1);
          end
          OP_RST: begin
            ctl.rstWrite = 1'b1;
            ctl.rstLevel = word.arg[0];
            nextPc       = pc + PC_W'(1);
          end
          OP_END: begin
            ctl.setDone = 1'b1;
            nextState   = ST_IDLE;
          end
          default: nextState = ST_IDLE;
        endcase
      end
      ST_DELAY: if (delayDone) begin
        nextPc    = pc + PC_W'(1);
        nextState = ST_FETCH;
      end
      ST_SEND: if (cmdReady) nextState = ST_DRAIN;
      ST_DRAIN: if (shifterIdle) begin
        nextPc    = pc + PC_W'(1);
        nextState = ST_FETCH;
      end
      ST_IDLE: if (ctrPending) begin
        ctl.startCtr = 1'b1;
        nextPc       = CTR_ENTRY;
        nextState    = ST_FETCH;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_FETCH;
      pc    <= '0;
    end else begin
      state <= nextState;
      pc    <= nextPc;
    end
  end

  // R7
  offer_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid);

  // R7
  drain_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !shifterIdle) |=> !cmdValid);

endmodule

// File: rtl/oled_seq_dpath.sv
module oled_seq_dpath
  import oled_seq_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              contrastReq,
  input  logic [BYTE_W-1:0] contrastVal,
  output logic              delayDone,
  output logic              ctrPending,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              csN,
  output logic              dcSel,
  output logic              oledRstN,
  output logic              done
);

  localparam int TICK_CYCLES = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int PRE_W       = (TICK_CYCLES < 2) ? 1 : $clog2(TICK_CYCLES);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [MS_W-1:0]   msLeft;
  logic [BYTE_W-1:0] reqVal, sendVal;

  assign delayDone = (msLeft == '0);

  // Millisecond prescaler, restarted on every load so each wait is exact
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      msLeft <= '0;
    end else if (ctl.loadDelay) begin
      preCnt <= '0;
      msLeft <= ctl.delayMs;
    end else if (msLeft != '0) begin
      if (preCnt == PRE_LAST) begin
        preCnt <= '0;
        msLeft <= msLeft - MS_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // Display lines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN      <= 1'b1;
      dcSel    <= 1'b1;
      oledRstN <= 1'b1;
      done     <= 1'b0;
    end else begin
      if (ctl.csWrite)  csN      <= ~ctl.csSelect;
      if (ctl.dcWrite)  dcSel    <= ctl.dcLevel;
      if (ctl.rstWrite) oledRstN <= ctl.rstLevel;
      if (ctl.setDone)  done     <= 1'b1;
    end
  end

  // Byte register and contrast request latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdByte    <= '0;
      reqVal     <= '0;
      sendVal    <= '0;
      ctrPending <= 1'b0;
    end else begin
      if (ctl.loadByte)     cmdByte <= ctl.byteVal;
      else if (ctl.loadCtr) cmdByte <= sendVal;
      if (ctl.startCtr) sendVal <= reqVal >> 1;
      if (contrastReq) begin
        ctrPending <= 1'b1;
        reqVal     <= contrastVal;
      end else if (ctl.startCtr) begin
        ctrPending <= 1'b0;
      end
    end
  end

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  // R10
  ctr_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startCtr |-> done);

  // R3
  rst_unselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oledRstN |-> csN);

  // R2
  ms_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msLeft != '0 && !ctl.loadDelay) |=> msLeft <= $past(msLeft));

endmodule

// File: rtl/oled_bringup_seq.sv
module oled_bringup_seq
  import oled_seq_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       contrastReq,
  input  logic [7:0] contrastVal,
  input  logic       cmdReady,
  input  logic       shifterIdle,
  output logic       cmdValid,
  output logic [7:0] cmdByte,
  output logic       csN,
  output logic       dcSel,
  output logic       oledRstN,
  output logic       done
);

  dpCtl_t ctl;
  logic   delayDone, ctrPending;

  oled_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .delayDone(delayDone), .ctrPending(ctrPending),
    .cmdReady(cmdReady), .shifterIdle(shifterIdle), .ctl(ctl), .cmdValid(cmdValid)
  );

  oled_seq_dpath #(.CLK_HZ(CLK_HZ)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .contrastReq(contrastReq),
    .contrastVal(contrastVal), .delayDone(delayDone), .ctrPending(ctrPending),
    .cmdByte(cmdByte), .csN(csN), .dcSel(dcSel), .oledRstN(oledRstN), .done(done)
  );

  // R4
  cmd_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (!csN && !dcSel));

  // R7
  byte_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> $stable(cmdByte));

  // R8
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(csN) && !$past(csN, 2)));

endmodule

// File: tb/tb_oled_bringup_seq.sv
`timescale 1ns/1ps
module tb_oled_bringup_seq;

  localparam int CLK_HZ = 20_000;
  localparam int T      = CLK_HZ / 1000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       contrastReq;
  logic [7:0] contrastVal;
  logic       cmdReady, shifterIdle, cmdValid, csN, dcSel, oledRstN, done;
  logic [7:0] cmdByte;

  always #2.5 clk = ~clk;

  oled_bringup_seq #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rstN(rstN), .contrastReq(contrastReq), .contrastVal(contrastVal),
    .cmdReady(cmdReady), .shifterIdle(shifterIdle), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .csN(csN), .dcSel(dcSel), .oledRstN(oledRstN), .done(done)
  );

  int testsRun = 0;
  int testsFailed = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] expBoot(input int i);
    case (i)
      0: return 8'hAE;  1: return 8'hB3;  2: return 8'h91;  3: return 8'hA8;
      4: return 8'h3F;  5: return 8'hA2;  6: return 8'h4C;  7: return 8'hA1;
      8: return 8'h00;  9: return 8'hAD; 10: return 8'h02; 11: return 8'hA0;
     12: return 8'h56; 13: return 8'h86; 14: return 8'hB8; 15: return 8'h01;
     16: return 8'h11; 17: return 8'h22; 18: return 8'h32; 19: return 8'h43;
     20: return 8'h54; 21: return 8'h65; 22: return 8'h76; 23: return 8'h81;
     24: return 8'h70; 25: return 8'hB2; 26: return 8'h51; 27: return 8'hB1;
     28: return 8'h55; 29: return 8'hBC; 30: return 8'h10; 31: return 8'hB4;
     32: return 8'h02; 33: return 8'hB0; 34: return 8'h28; 35: return 8'hBE;
     36: return 8'h1C; 37: return 8'hBF; 38: return 8'h0F; 39: return 8'hA5;
     40: return 8'hAF; 41: return 8'hA4;
      default: return 8'hXX;
    endcase
  endfunction

  function automatic logic [7:0] expLevel(input logic [7:0] v);
    return v >> 1;
  endfunction

  // Shifter model with random stalls and busy time
  int   busyCnt;
  logic stall;
  assign shifterIdle = (busyCnt == 0);
  assign cmdReady    = shifterIdle && !stall;

  always @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= 0;
      stall   <= 1'b0;
    end else begin
      stall <= ($urandom_range(0, 3) == 0);
      if (cmdValid && cmdReady) busyCnt <= $urandom_range(1, 6);
      else if (busyCnt != 0)    busyCnt <= busyCnt - 1;
    end
  end

  // Monitor
  int         cyc = 0;
  int         nLog = 0;
  logic [7:0] byteLog [0:255];
  logic       csLog   [0:255];
  logic       dcLog   [0:255];
  int         cycLog  [0:255];
  int holdErr = 0, offerErr = 0, doneDrop = 0;
  int dcFall = -1, rstFall = -1, rstRise = -1, lastCsRise = -1, doneRise = -1;
  int csToDone = -1;
  logic csAtDcFall = 1'b0;
  logic prevValid = 0, prevReady = 0, prevDc = 1, prevRst = 1, prevCs = 1, prevDone = 0;
  logic [7:0] prevByte = 0;

  always @(posedge clk) begin
    cyc++;
    if (rstN) begin
      if (cmdValid && cmdReady && nLog < 256) begin
        byteLog[nLog] = cmdByte;
        csLog[nLog]   = csN;
        dcLog[nLog]   = dcSel;
        cycLog[nLog]  = cyc;
        nLog++;
      end
      if (prevValid && !prevReady && (!cmdValid || cmdByte != prevByte)) holdErr++;
      if (cmdValid && !prevValid && !shifterIdle) offerErr++;
      if (prevDc && !dcSel && dcFall < 0) begin dcFall = cyc; csAtDcFall = csN; end
      if (prevRst && !oledRstN && rstFall < 0) rstFall = cyc;
      if (!prevRst && oledRstN && rstRise < 0) rstRise = cyc;
      if (!prevCs && csN) lastCsRise = cyc;
      if (!prevDone && done) begin doneRise = cyc; csToDone = cyc - lastCsRise; end
      if (prevDone && !done) doneDrop++;
    end
    prevValid = cmdValid; prevReady = cmdReady; prevByte = cmdByte;
    prevDc = dcSel; prevRst = oledRstN; prevCs = csN; prevDone = done;
  end

  task automatic pulseReq(input logic [7:0] v);
    @(negedge clk);
    contrastReq = 1'b1;
    contrastVal = v;
    @(negedge clk);
    contrastReq = 1'b0;
  endtask

  task automatic waitBytes(input int n);
    while (nLog < n) @(negedge clk);
  endtask

  task automatic waitCsHigh();
    while (!csN) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runContrast(input logic [7:0] v);
    int base;
    base = nLog;
    pulseReq(v);
    waitBytes(base + 2);
    waitCsHigh();
    // R9
    chk(byteLog[base] == 8'h81, "R9", "contrast opcode", byteLog[base], 8'h81);
    chk(byteLog[base+1] == expLevel(v), "R9", "contrast level", byteLog[base+1], expLevel(v));
    chk(csN == 1'b1 && nLog == base + 2, "R9", "cs released, 2 bytes", nLog - base, 2);
  endtask

  int relCyc;

  initial begin
    void'($urandom(32'h5EED_0B1E));
    rstN = 1'b0; contrastReq = 1'b0; contrastVal = 8'h00;
    repeat (3) @(negedge clk);
    // R1
    chk(csN == 1'b1, "R1", "csN in reset", csN, 1);
    chk(dcSel == 1'b1, "R1", "dcSel in reset", dcSel, 1);
    chk(oledRstN == 1'b1, "R1", "oledRstN in reset", oledRstN, 1);
    chk(cmdValid == 1'b0, "R1", "cmdValid in reset", cmdValid, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rstN = 1'b1;
    relCyc = cyc;

    begin
      logic [7:0] v0;
      v0 = 8'($urandom_range(0, 255));
      repeat (60) @(negedge clk);
      pulseReq(v0);
      while (!done) @(negedge clk);
      waitBytes(44);
      waitCsHigh();

      // R2
      chk(dcFall - relCyc >= 10*T && dcFall - relCyc <= 10*T + 10, "R2",
          "dc low time", dcFall - relCyc, 10*T);
      chk(csAtDcFall == 1'b1, "R2", "cs at dc fall", csAtDcFall, 1);
      // R3
      chk(rstFall > dcFall, "R3", "reset after dc", rstFall, dcFall);
      chk(rstRise - rstFall >= 18*T && rstRise - rstFall <= 18*T + 6, "R3",
          "reset pulse width", rstRise - rstFall, 18*T);
      // R5 and R4
      for (int i = 0; i < 42; i++) begin
        chk(byteLog[i] == expBoot(i), "R5", $sformatf("boot byte %0d", i),
            byteLog[i], expBoot(i));
        chk(csLog[i] == 1'b0 && dcLog[i] == 1'b0, "R4", $sformatf("lines at byte %0d", i),
            {csLog[i], dcLog[i]}, 0);
      end
      // R6
      chk(cycLog[41] - cycLog[40] >= 200*T && cycLog[41] - cycLog[40] <= 200*T + 40,
          "R6", "AF to A4 gap", cycLog[41] - cycLog[40], 200*T);
      // R8
      chk(csToDone == 1, "R8", "cs release to done", csToDone, 1);
      chk(doneRise > cycLog[41], "R8", "done after last byte", doneRise, cycLog[41]);
      // R10
      chk(byteLog[42] == 8'h81, "R10", "held opcode", byteLog[42], 8'h81);
      chk(byteLog[43] == expLevel(v0), "R10", "held level", byteLog[43], expLevel(v0));
      chk(cycLog[42] > doneRise, "R10", "held request after done", cycLog[42], doneRise);
      chk(csLog[42] == 1'b0 && csLog[43] == 1'b0, "R4", "cs during contrast",
          {csLog[42], csLog[43]}, 0);
    end

    // R9 random and corner levels
    for (int k = 0; k < 6; k++) runContrast(8'($urandom_range(0, 255)));
    runContrast(8'h00);
    runContrast(8'hFF);
    runContrast(8'h01);

    // R11 request during an active contrast transfer
    begin
      int base;
      logic [7:0] v1, v2;
      v1 = 8'($urandom_range(0, 255));
      v2 = 8'($urandom_range(0, 255));
      base = nLog;
      pulseReq(v1);
      waitBytes(base + 1);
      pulseReq(v2);
      waitBytes(base + 4);
      waitCsHigh();
      chk(byteLog[base] == 8'h81 && byteLog[base+2] == 8'h81, "R11", "two opcodes",
          {byteLog[base], byteLog[base+2]}, 16'h8181);
      chk(byteLog[base+1] == expLevel(v1), "R11", "first level", byteLog[base+1], expLevel(v1));
      chk(byteLog[base+3] == expLevel(v2), "R11", "second level", byteLog[base+3], expLevel(v2));
      chk(nLog == base + 4, "R11", "byte count", nLog - base, 4);
    end

    // R7
    chk(holdErr == 0, "R7", "offer dropped or changed before accept", holdErr, 0);
    chk(offerErr == 0, "R7", "offer while shifter busy", offerErr, 0);
    // R8
    chk(done == 1'b1 && doneDrop == 0, "R8", "done sticky", doneDrop, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule